// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control core of a parallel-output sampling converter. An active-low start input begins a conversion. A busy flag stays high while the conversion runs. The conversion is timed by a separate conversion clock. The core samples that clock on a free-running system clock and counts its rising edges. When the conversion ends, the result from a stub sample input is captured into an output register. A host reads that register over a parallel bus, and the bus is driven only while chip-select and read are both low and no conversion is running.

The level of the start input at the moment busy falls picks the operating mode. If the start input is high, the core stays awake for fast back-to-back conversions. If it is low, the core goes to sleep. A rising edge of the start input wakes the core, and a wake-up interval counted in system-clock cycles must then elapse before busy can rise. A start request that arrives while the core is waking is held until that interval ends. A new falling edge of the start input during a conversion restarts that conversion from its beginning.

Top module: `adc_conv_seq`

## Requirements
- R1: Out of reset, busy is low and the bus is not driven. A falling edge of `convst_n` seen while awake sets busy high from the next system-clock cycle.
- R2: A falling edge of `convst_n` while busy is high clears the edge count and restarts the conversion, so busy stays high for a full conversion measured from that edge.
- R3: At the cycle where busy falls, `convst_n` high keeps the core awake, and the next falling edge starts at once. `convst_n` low puts the core to sleep.
- R4: In sleep, only a rising edge of `convst_n` has an effect. Busy rises no earlier than WAKE system cycles after that edge is detected, where WAKE = ceil(WAKE_PS / SYS_CLK_PS) (250 by default).
- R5: A falling edge of `convst_n` that arrives during the wake-up interval is held. If `convst_n` is still low when the interval ends, busy rises in exactly that cycle.
- R6: If `convst_n` is high when the wake-up interval ends, the core is awake and idle. Busy rises only after a later falling edge.
- R7: A conversion ends on the NCLK-th rising edge of `conv_clk` seen after busy rose, where NCLK = RES_BITS + 2 (12 for 10 bits, 14 for 12 bits). Busy falls one system cycle after that edge is detected.
- R8: `sample_in` is captured into the result register in the cycle busy falls. The result is held unchanged until the next conversion ends.
- R9: `db_oe` is 1 exactly when `cs_n` = 0, `rd_n` = 0 and busy = 0. `db` then carries the result; otherwise `db` is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| convst_n | input | 1 | Active-low convert start, synchronous to clk |
| conv_clk | input | 1 | Conversion clock, sampled on clk |
| sample_in | input | RES_BITS | Stub conversion result |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| busy | output | 1 | High while a conversion runs |
| db_oe | output | 1 | High while the data bus is driven |
| db | output | RES_BITS | Parallel result bus, high impedance when not read |

## Verification
The hardest situation to reach is a start request that falls inside the wake-up window. It needs a conversion that ends with the start input held low, then a rising edge, and then a falling edge a few cycles later, well before the wake-up count expires. The bench builds this sequence directly. It then counts system cycles from the rising edge to the first busy cycle and compares the count with WAKE plus one. A second pass wakes the core with no request, to show that it then comes up idle.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int RES_BITS   = 12,
  parameter int SYS_CLK_PS = 4000,
  parameter int WAKE_PS    = 1000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                convst_n,
  input  logic                conv_clk,
  input  logic [RES_BITS-1:0] sample_in,
  input  logic                cs_n,
  input  logic                rd_n,
  output logic                busy,
  output logic                db_oe,
  output logic [RES_BITS-1:0] db
);
  localparam int NCLK = RES_BITS + 2;
  localparam int WRAW = (WAKE_PS + SYS_CLK_PS - 1) / SYS_CLK_PS;
  localparam int WAKE = (WRAW < 1) ? 1 : WRAW;
  localparam int CW   = $clog2(NCLK + 1);
  localparam int WW   = $clog2(WAKE + 1);

  typedef enum logic [1:0] {AWAKE, CONV, SLEEP, WAKING} st_t;

  st_t                st;
  logic               cv_q, ck_q;
  logic [CW-1:0]      cnt;
  logic [WW-1:0]      wcnt;
  logic [RES_BITS-1:0] res;
  logic               cv_fall, cv_rise, ck_rise, last_edge, wake_done;

  assign cv_fall   = cv_q & ~convst_n;
  assign cv_rise   = ~cv_q & convst_n;
  assign ck_rise   = ~ck_q & conv_clk;
  assign last_edge = (st == CONV) && !cv_fall && ck_rise && (cnt == CW'(NCLK - 1));
  assign wake_done = (st == WAKING) && (wcnt == WW'(WAKE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= AWAKE;
      cv_q <= 1'b1;
      ck_q <= 1'b0;
      cnt  <= '0;
      wcnt <= '0;
      res  <= '0;
    end else begin
      cv_q <= convst_n;
      ck_q <= conv_clk;
      case (st)
        AWAKE:
          if (cv_fall) begin
            st  <= CONV;
            cnt <= '0;
          end
        CONV:
          if (cv_fall) cnt <= '0;
          else if (last_edge) begin
            res <= sample_in;
            st  <= convst_n ? AWAKE : SLEEP;
          end else if (ck_rise) cnt <= cnt + 1'b1;
        SLEEP:
          if (cv_rise) begin
            st   <= WAKING;
            wcnt <= '0;
          end
        WAKING:
          if (wake_done) begin
            st  <= convst_n ? AWAKE : CONV;
            cnt <= '0;
          end else wcnt <= wcnt + 1'b1;
        default: st <= AWAKE;
      endcase
    end
  end

  assign busy  = (st == CONV);
  assign db_oe = ~cs_n & ~rd_n & ~busy;
  assign db    = db_oe ? res : 'z;

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CONV && cv_fall) |=> (busy && cnt == '0));  // R2
  AST_STAY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(convst_n)) |-> (st == AWAKE));  // R3
  AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(convst_n)) |-> (st == SLEEP));  // R3
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLEEP && !cv_rise) |=> (st == SLEEP));  // R4
  AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(st) == WAKING) |-> ($past(wcnt) == WW'(WAKE - 1)));  // R4
  AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_done && convst_n) |=> (st == AWAKE && !busy));  // R6
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == CW'(NCLK - 1) && $past(ck_rise)));  // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(res));  // R8
endmodule

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
  localparam int RB = 12;
  localparam int NC = RB + 2;
  localparam int W  = 250;

  logic clk = 0, rst_n = 0, convst_n = 1, conv_clk = 0, cs_n = 1, rd_n = 1;
  logic [RB-1:0] sample_in = '0;
  logic busy, db_oe;
  logic [RB-1:0] db;
  int total = 0, bad = 0;

  adc_conv_seq #(.RES_BITS(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .conv_clk(conv_clk),
    .sample_in(sample_in), .cs_n(cs_n), .rd_n(rd_n),
    .busy(busy), .db_oe(db_oe), .db(db));

  always #2 clk = ~clk;

  int kdiv = 0;
  always @(negedge clk) begin
    if (kdiv == 2) begin kdiv = 0; conv_clk = ~conv_clk; end
    else kdiv++;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // behavioural reference: 0 awake, 1 converting, 2 sleeping, 3 waking
  int m_st, m_cnt, m_w, m_res;
  bit pc, pk, fe, re, ke;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_w = 0; m_res = 0; pc = 1; pk = 0;
    end else begin
      fe = pc && !convst_n;
      re = !pc && convst_n;
      ke = !pk && conv_clk;
      if (m_st == 0) begin
        if (fe) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 1) begin
        if (fe) m_cnt = 0;
        else if (ke) begin
          if (m_cnt == NC - 1) begin m_res = int'(sample_in); m_st = convst_n ? 0 : 2; end
          else m_cnt++;
        end
      end else if (m_st == 2) begin
        if (re) begin m_st = 3; m_w = 0; end
      end else begin
        m_w++;
        if (m_w == W) begin m_st = convst_n ? 0 : 1; m_cnt = 0; end
      end
      pc = convst_n;
      pk = conv_clk;
    end
  end

  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      bit eo;
      eo = !cs_n && !rd_n && (m_st != 1);
      chk(busy === (m_st == 1), "R1 R7 busy vs model", int'(busy), int'(m_st == 1));
      chk(db_oe === eo, "R9 bus enable vs model", int'(db_oe), int'(eo));
      if (eo) chk(int'(db) == m_res, "R8 bus data vs model", int'(db), m_res);
    end
  end

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, k;
    bit seen;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(db_oe == 0, "R1 reset bus idle", int'(db_oe), 0);

    sample_in = 12'hA5C;
    convst_n = 0;
    @(negedge clk);
    chk(busy == 1, "R1 busy after start", int'(busy), 1);
    convst_n = 1; cs_n = 0; rd_n = 0;
    @(negedge clk);
    chk(db_oe == 0, "R9 no drive while busy", int'(db_oe), 0);
    busy_len(n);
    chk(n >= 78 && n <= 83, "R7 conversion length", n + 2, NC * 6);
    chk(db_oe == 1, "R9 drive after end", int'(db_oe), 1);
    chk(db == 12'hA5C, "R8 captured result", int'(db), 'hA5C);
    sample_in = 12'h123;
    repeat (3) @(negedge clk);
    chk(db == 12'hA5C, "R8 result held", int'(db), 'hA5C);
    cs_n = 1;
    @(negedge clk);
    chk(db_oe == 0, "R9 no drive without select", int'(db_oe), 0);
    rd_n = 1;

    convst_n = 0;
    @(negedge clk);
    chk(busy == 1, "R3 awake start immediate", int'(busy), 1);
    convst_n = 1;
    repeat (20) @(negedge clk);
    convst_n = 0;
    @(negedge clk);
    convst_n = 1;
    busy_len(n);
    chk(n >= 78 && n <= 83, "R2 restart full length", n + 1, NC * 6);

    sample_in = 12'h3C7;
    repeat (3) @(negedge clk);
    convst_n = 0;
    @(negedge clk);
    busy_len(n);
    repeat (10) @(negedge clk);
    chk(busy == 0, "R3 sleep holds while low", int'(busy), 0);

    convst_n = 1;
    k = 0;
    while (!busy && k < W + 50) begin
      @(negedge clk);
      k++;
      if (k == 5) convst_n = 0;
    end
    chk(k == W + 1, "R4 R5 pending start after wake", k, W + 1);
    busy_len(n);
    chk(db_oe == 0, "R9 no read strobe", int'(db_oe), 0);
    cs_n = 0; rd_n = 0;
    @(negedge clk);
    chk(db == 12'h3C7, "R8 result after sleep cycle", int'(db), 'h3C7);
    cs_n = 1; rd_n = 1;

    convst_n = 1;
    seen = 0;
    repeat (W + 20) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    chk(seen == 0, "R6 no busy without request", int'(seen), 0);
    convst_n = 0;
    @(negedge clk);
    chk(busy == 1, "R6 start after idle wake", int'(busy), 1);
    convst_n = 1;
    busy_len(n);
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule